// File: doc/BRIEF.md
# Microcoded I2C Master Command Sequencer

This block is the control core of an I2C master. The bus transaction is not fixed in hardware. Software fills a 32-slot store with 5-bit command words, supplies the address bytes and a loop count, and raises a launch pulse. The sequencer then steps through the slots starting at slot 0. Each word turns into one bus primitive: start, repeated start, stop, write a byte, read a byte, drive ACK, drive NACK, or sample the ACK bit. That primitive goes to a separate bit-level bus engine over a request/done handshake.

One counted back-jump lets a single short program move any number of bytes. Byte data passes through an 8-bit transmit FIFO and an 8-bit receive FIFO. Whether a missing acknowledge aborts the program or is ignored is chosen per slot by the opcode.

Completion, abort, illegal-opcode and FIFO watermark events collect in a raw interrupt vector. Raw bits are cleared by writing ones. The raw vector is masked by an enable vector. Register decode and SCL/SDA pin timing sit outside this block.

Top module: `i2c_microseq`

## Requirements
- R1: After reset the block is idle (`busy`=0, `engReq`=0), `rawIrq` is zero, the RX FIFO is empty (`rxNotEmpty`=0) and the TX FIFO is not full (`txNotFull`=1).
- R2: A `launch` pulse while `enable`=1 and idle starts execution at slot 0, and `busy` is 1 after the next clock edge. A `launch` while `enable`=0 is ignored.
- R3: Each bus primitive is presented as follows. `engReq` is held high with stable `engOp` and `engByte` until a cycle with `engDone`=1. `engNack`=1 in that cycle reports a NACK. The `engOp` codes are: 0 start, 1 repeated start, 2 stop, 3 write byte, 4 read byte, 5 drive ACK, 6 drive NACK, 7 sample ACK.
- R4: Opcode meanings:
  - 0x01 issues start.
  - 0x1E issues repeated start.
  - 0x1F issues stop.
  - 0x05 writes `addrWord[7:0]`.
  - 0x04 writes `addrWord[15:8]`.
  - 0x1D pops the TX FIFO head into a hold register.
  - 0x09 writes the hold register.
  - 0x16 drives ACK.
  - 0x17 drives NACK.
- R5: The loop opcode 0x18 works on a counter that is loaded from `loopInit` at launch. If the counter is nonzero, it decrements and execution jumps to slot `jumpDest`. If it is zero, execution falls through. A count of N runs the loop body N+1 times.
- R6: Opcode 0x00 ends the program, returns the block to idle and sets `rawIrq[12]`.
- R7: Opcode 0x13 samples ACK. If a NACK comes back, the program ends at once and sets `rawIrq[0]`, and no further primitive is issued. Opcode 0x15 also samples ACK, but execution continues regardless of the result.
- R8: Any opcode not listed above ends the program without a bus request. It sets `rawIrq[11]` and leaves `rawIrq[12]` clear.
- R9: Opcode 0x1D with an empty TX FIFO, or opcode 0x12 with a full RX FIFO, stalls on that slot with `busy`=1 and no request until data or space appears.
- R10: Opcode 0x12 issues a read. The byte returned on `engRxByte` with `engDone` is pushed into the RX FIFO. Bytes leave the FIFO in order: `rxData` shows the head and `rxPop` removes it.
- R11: `rawIrq[2]` is set in every cycle where the RX count is greater than `rxWater`. `rawIrq[4]` is set in every cycle where the TX count is less than `txWater`.
- R12: When `irqClr`=1, each `rawIrq` bit with a one in `irqClrMask` is cleared and the other bits are kept. `maskedIrq` equals `rawIrq & irqEn`, and `irq` is the OR of `maskedIrq`.
- R13: While `enable`=0 the sequencer is forced idle, which drops any running program and any outstanding request.
- R14: `rxNotEmpty` is 1 exactly when the RX FIFO holds data. `txNotFull` is 0 exactly when the TX FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low holds the sequencer idle |
| launch | input | 1 | Start pulse for the command program |
| cmdWr | input | 1 | Command store write strobe |
| cmdWrAddr | input | 5 | Command slot index |
| cmdWrData | input | 5 | Opcode written to the slot |
| addrWord | input | 16 | Lower address byte [7:0], upper address byte [15:8] |
| loopInit | input | 8 | Loop count loaded at launch |
| jumpDest | input | 5 | Slot index taken by a jump |
| txPush | input | 1 | Push `txData` into the TX FIFO |
| txData | input | 8 | Transmit byte |
| rxPop | input | 1 | Remove the RX FIFO head |
| rxData | output | 8 | RX FIFO head |
| rxNotEmpty | output | 1 | RX FIFO holds data |
| txNotFull | output | 1 | TX FIFO has space |
| txWater | input | FIFO_DEPTH log2 + 1 | TX low watermark |
| rxWater | input | FIFO_DEPTH log2 + 1 | RX high watermark |
| irqEn | input | 13 | Interrupt enable vector |
| irqClr | input | 1 | Clear strobe for raw interrupt bits |
| irqClrMask | input | 13 | Ones select the raw bits to clear |
| rawIrq | output | 13 | Raw interrupt vector |
| maskedIrq | output | 13 | Raw AND enable |
| irq | output | 1 | Any masked bit set |
| busy | output | 1 | A program is running or stalled |
| engReq | output | 1 | Primitive request to the bus engine |
| engOp | output | 3 | Primitive code |
| engByte | output | 8 | Byte for a write primitive |
| engDone | input | 1 | Bus engine finished the primitive |
| engNack | input | 1 | NACK seen, valid with `engDone` |
| engRxByte | input | 8 | Received byte, valid with `engDone` |

## Verification
The bench builds the block with `FIFO_DEPTH`=4 and keeps the 32-slot store. With the shallow FIFO, a five-byte read loop fills the RX FIFO and stalls the receive opcode within a few dozen cycles. The same setting lets a handful of pushes reach the TX-full flag and both watermark thresholds. The bus engine is modelled by a responder that records each primitive and can answer every ACK sample with a NACK. This exercises both the abort path and the ignore path of the ACK opcodes.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [4:0] {
    OPC_EXIT     = 5'h00,
    OPC_START    = 5'h01,
    OPC_ADDR_HI  = 5'h04,
    OPC_ADDR_LO  = 5'h05,
    OPC_SEND_TX  = 5'h09,
    OPC_RECV     = 5'h12,
    OPC_ACK_CHK  = 5'h13,
    OPC_ACK_IGN  = 5'h15,
    OPC_ACK_OUT  = 5'h16,
    OPC_NACK_OUT = 5'h17,
    OPC_LOOP     = 5'h18,
    OPC_TX_LOAD  = 5'h1D,
    OPC_RESTART  = 5'h1E,
    OPC_STOP     = 5'h1F
  } opcode_e;

  typedef enum logic [2:0] {
    BUS_START   = 3'd0,
    BUS_RESTART = 3'd1,
    BUS_STOP    = 3'd2,
    BUS_WRITE   = 3'd3,
    BUS_READ    = 3'd4,
    BUS_ACK     = 3'd5,
    BUS_NACK    = 3'd6,
    BUS_SAMPLE  = 3'd7
  } busOp_e;

  localparam int IRQ_W     = 13;
  localparam int IRQ_NACK  = 0;
  localparam int IRQ_RXLVL = 2;
  localparam int IRQ_TXLVL = 4;
  localparam int IRQ_BADOP = 11;
  localparam int IRQ_DONE  = 12;

  // Strobes from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic txPop;
    logic rxPush;
    logic cntLoad;
    logic cntDec;
    logic setDone;
    logic setNack;
    logic setBadOp;
  } ctlStrobe_t;

endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  popData,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/i2cseq_datapath.sv
module i2cseq_datapath
  import i2cseq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 64,
  parameter  int LOOP_W     = 8,
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [LOOP_W-1:0] loopInit,
  input  logic              txPush,
  input  logic [7:0]        txData,
  input  logic              rxPop,
  input  logic [7:0]        engRxByte,
  input  logic [CNT_W-1:0]  txWater,
  input  logic [CNT_W-1:0]  rxWater,
  input  logic [IRQ_W-1:0]  irqEn,
  input  logic              irqClr,
  input  logic [IRQ_W-1:0]  irqClrMask,
  output logic [7:0]        holdByte,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              cntZero,
  output logic [7:0]        rxData,
  output logic              rxNotEmpty,
  output logic              txNotFull,
  output logic [IRQ_W-1:0]  rawIrq,
  output logic [IRQ_W-1:0]  maskedIrq
);
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [7:0]        txHead;
  logic              txFull, rxEmpty;
  logic [LOOP_W-1:0] loopCnt;
  logic [IRQ_W-1:0]  setVec, clrVec;

  i2cseq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(txPush), .pushData(txData),
    .pop(strobe.txPop), .popData(txHead),
    .count(txCount), .empty(txEmpty), .full(txFull)
  );

  i2cseq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.rxPush), .pushData(engRxByte),
    .pop(rxPop), .popData(rxData),
    .count(rxCount), .empty(rxEmpty), .full(rxFull)
  );

  assign rxNotEmpty = !rxEmpty;
  assign txNotFull  = !txFull;
  assign cntZero    = (loopCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte <= '0;
      loopCnt  <= '0;
    end else begin
      if (strobe.txPop)        holdByte <= txHead;
      if (strobe.cntLoad)      loopCnt  <= loopInit;
      else if (strobe.cntDec)  loopCnt  <= loopCnt - 1'b1;
    end
  end

  always_comb begin
    setVec = '0;
    setVec[IRQ_NACK]  = strobe.setNack;
    setVec[IRQ_BADOP] = strobe.setBadOp;
    setVec[IRQ_DONE]  = strobe.setDone;
    setVec[IRQ_RXLVL] = (rxCount > rxWater);
    setVec[IRQ_TXLVL] = (txCount < txWater);
    clrVec = irqClr ? irqClrMask : '0;
  end

  // A new event in the clear cycle survives the clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawIrq <= '0;
    else       rawIrq <= (rawIrq & ~clrVec) | setVec;
  end

  assign maskedIrq = rawIrq & irqEn;
endmodule

// File: rtl/i2cseq_control.sv
module i2cseq_control
  import i2cseq_pkg::*;
#(
  parameter  int SLOTS = 32,
  localparam int PCW   = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic           launch,
  input  logic           cmdWr,
  input  logic [PCW-1:0] cmdWrAddr,
  input  logic [4:0]     cmdWrData,
  input  logic [15:0]    addrWord,
  input  logic [PCW-1:0] jumpDest,
  input  logic [7:0]     holdByte,
  input  logic           txEmpty,
  input  logic           rxFull,
  input  logic           cntZero,
  input  logic           engDone,
  input  logic           engNack,
  output ctlStrobe_t     strobe,
  output logic           busy,
  output logic           engReq,
  output logic [2:0]     engOp,
  output logic [7:0]     engByte
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WAIT} state_e;

  state_e         st, stNext;
  logic [PCW-1:0] pc, pcNext;
  logic [4:0]     store [SLOTS];
  logic [4:0]     word;
  busOp_e         opReg, opNext;
  logic [7:0]     byteReg, byteNext;
  logic           strictReg, strictNext;
  logic           issue;

  assign word = store[pc];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) store[i] <= '0;
    end else if (cmdWr) begin
      store[cmdWrAddr] <= cmdWrData;
    end
  end

  always_comb begin
    strobe     = '0;
    stNext     = st;
    pcNext     = pc;
    opNext     = opReg;
    byteNext   = byteReg;
    strictNext = strictReg;
    issue      = 1'b0;
    if (!enable) begin
      stNext = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (launch) begin
            stNext         = ST_EXEC;
            pcNext         = '0;
            strobe.cntLoad = 1'b1;
          end
        end
        ST_EXEC: begin
          case (opcode_e'(word))
            OPC_EXIT: begin
              strobe.setDone = 1'b1;
              stNext         = ST_IDLE;
            end
            OPC_START:    begin issue = 1'b1; opNext = BUS_START;   end
            OPC_RESTART:  begin issue = 1'b1; opNext = BUS_RESTART; end
            OPC_STOP:     begin issue = 1'b1; opNext = BUS_STOP;    end
            OPC_ACK_OUT:  begin issue = 1'b1; opNext = BUS_ACK;     end
            OPC_NACK_OUT: begin issue = 1'b1; opNext = BUS_NACK;    end
            OPC_ADDR_LO: begin
              issue = 1'b1; opNext = BUS_WRITE; byteNext = addrWord[7:0];
            end
            OPC_ADDR_HI: begin
              issue = 1'b1; opNext = BUS_WRITE; byteNext = addrWord[15:8];
            end
            OPC_SEND_TX: begin
              issue = 1'b1; opNext = BUS_WRITE; byteNext = holdByte;
            end
            OPC_ACK_CHK: begin
              issue = 1'b1; opNext = BUS_SAMPLE; strictNext = 1'b1;
            end
            OPC_ACK_IGN: begin
              issue = 1'b1; opNext = BUS_SAMPLE; strictNext = 1'b0;
            end
            OPC_RECV: begin
              if (!rxFull) begin
                issue = 1'b1; opNext = BUS_READ;
              end
            end
            OPC_TX_LOAD: begin
              if (!txEmpty) begin
                strobe.txPop = 1'b1;
                pcNext       = pc + 1'b1;
              end
            end
            OPC_LOOP: begin
              if (!cntZero) begin
                strobe.cntDec = 1'b1;
                pcNext        = jumpDest;
              end else begin
                pcNext = pc + 1'b1;
              end
            end
            default: begin
              strobe.setBadOp = 1'b1;
              stNext          = ST_IDLE;
            end
          endcase
          if (issue) stNext = ST_WAIT;
        end
        ST_WAIT: begin
          if (engDone) begin
            pcNext = pc + 1'b1;
            stNext = ST_EXEC;
            if (opReg == BUS_READ) strobe.rxPush = 1'b1;
            if (opReg == BUS_SAMPLE && strictReg && engNack) begin
              strobe.setNack = 1'b1;
              stNext         = ST_IDLE;
            end
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      pc        <= '0;
      opReg     <= BUS_START;
      byteReg   <= '0;
      strictReg <= 1'b0;
    end else begin
      st        <= stNext;
      pc        <= pcNext;
      opReg     <= opNext;
      byteReg   <= byteNext;
      strictReg <= strictNext;
    end
  end

  assign busy    = (st != ST_IDLE);
  assign engReq  = (st == ST_WAIT);
  assign engOp   = opReg;
  assign engByte = byteReg;
endmodule

// File: rtl/i2c_microseq.sv
module i2c_microseq
  import i2cseq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 64,
  parameter  int CMD_SLOTS  = 32,
  parameter  int LOOP_W     = 8,
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1,
  localparam int PCW        = $clog2(CMD_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              launch,
  input  logic              cmdWr,
  input  logic [PCW-1:0]    cmdWrAddr,
  input  logic [4:0]        cmdWrData,
  input  logic [15:0]       addrWord,
  input  logic [LOOP_W-1:0] loopInit,
  input  logic [PCW-1:0]    jumpDest,
  input  logic              txPush,
  input  logic [7:0]        txData,
  input  logic              rxPop,
  output logic [7:0]        rxData,
  output logic              rxNotEmpty,
  output logic              txNotFull,
  input  logic [CNT_W-1:0]  txWater,
  input  logic [CNT_W-1:0]  rxWater,
  input  logic [12:0]       irqEn,
  input  logic              irqClr,
  input  logic [12:0]       irqClrMask,
  output logic [12:0]       rawIrq,
  output logic [12:0]       maskedIrq,
  output logic              irq,
  output logic              busy,
  output logic              engReq,
  output logic [2:0]        engOp,
  output logic [7:0]        engByte,
  input  logic              engDone,
  input  logic              engNack,
  input  logic [7:0]        engRxByte
);
  ctlStrobe_t strobe;
  logic [7:0] holdByte;
  logic       txEmpty, rxFull, cntZero;

  i2cseq_control #(.SLOTS(CMD_SLOTS)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .launch(launch),
    .cmdWr(cmdWr), .cmdWrAddr(cmdWrAddr), .cmdWrData(cmdWrData),
    .addrWord(addrWord), .jumpDest(jumpDest), .holdByte(holdByte),
    .txEmpty(txEmpty), .rxFull(rxFull), .cntZero(cntZero),
    .engDone(engDone), .engNack(engNack),
    .strobe(strobe), .busy(busy),
    .engReq(engReq), .engOp(engOp), .engByte(engByte)
  );

  i2cseq_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .LOOP_W(LOOP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loopInit(loopInit),
    .txPush(txPush), .txData(txData), .rxPop(rxPop), .engRxByte(engRxByte),
    .txWater(txWater), .rxWater(rxWater),
    .irqEn(irqEn), .irqClr(irqClr), .irqClrMask(irqClrMask),
    .holdByte(holdByte), .txEmpty(txEmpty), .rxFull(rxFull), .cntZero(cntZero),
    .rxData(rxData), .rxNotEmpty(rxNotEmpty), .txNotFull(txNotFull),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq)
  );

  assign irq = |maskedIrq;
endmodule

// File: rtl/i2c_microseq_chk.sv
module i2c_microseq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        busy,
  input logic        engReq,
  input logic        engDone,
  input logic [2:0]  engOp,
  input logic [7:0]  engByte,
  input logic [12:0] rawIrq
);
  // R3: a request stays up, unchanged, until the engine answers
  p_hold_request_r3: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && !engDone && enable) |=> (engReq && $stable(engOp) && $stable(engByte)));

  // R13: disabling forces the sequencer idle on the next edge
  p_idle_when_off_r13: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

  // R13: no request leaves an idle sequencer
  p_no_req_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !engReq);

  // R6: completion is flagged only as the program ends
  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawIrq[12]) |-> !busy);

  // R7: a NACK abort ends the program
  p_nack_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawIrq[0]) |-> !busy);

  // R8: an undefined opcode ends the program
  p_badop_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawIrq[11]) |-> !busy);
endmodule

bind i2c_microseq i2c_microseq_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .busy(busy),
  .engReq(engReq), .engDone(engDone), .engOp(engOp),
  .engByte(engByte), .rawIrq(rawIrq)
);

// File: tb/i2c_microseq_test.sv
`timescale 1ns/1ps
module i2c_microseq_test;
  localparam int FD = 4;
  localparam int CW = $clog2(FD) + 1;

  logic        clk = 0;
  logic        rstN = 0;
  logic        enable = 0, launch = 0, cmdWr = 0;
  logic [4:0]  cmdWrAddr = 0, cmdWrData = 0, jumpDest = 0;
  logic [15:0] addrWord = 0;
  logic [7:0]  loopInit = 0;
  logic        txPush = 0, rxPop = 0;
  logic [7:0]  txData = 0, rxData;
  logic        rxNotEmpty, txNotFull;
  logic [CW-1:0] txWater = 0, rxWater = 3'd7;
  logic [12:0] irqEn = 0, irqClrMask = 0, rawIrq, maskedIrq;
  logic        irqClr = 0, irq, busy, engReq;
  logic [2:0]  engOp;
  logic [7:0]  engByte, engRxByte = 0;
  logic        engDone = 0, engNack = 0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [2:0] logOp [64];
  logic [7:0] logByte [64];
  int  logN = 0;
  int  rdCnt = 0;
  bit  nackAll = 0;

  i2c_microseq #(.FIFO_DEPTH(FD)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .launch(launch),
    .cmdWr(cmdWr), .cmdWrAddr(cmdWrAddr), .cmdWrData(cmdWrData),
    .addrWord(addrWord), .loopInit(loopInit), .jumpDest(jumpDest),
    .txPush(txPush), .txData(txData), .rxPop(rxPop), .rxData(rxData),
    .rxNotEmpty(rxNotEmpty), .txNotFull(txNotFull),
    .txWater(txWater), .rxWater(rxWater),
    .irqEn(irqEn), .irqClr(irqClr), .irqClrMask(irqClrMask),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq), .irq(irq), .busy(busy),
    .engReq(engReq), .engOp(engOp), .engByte(engByte),
    .engDone(engDone), .engNack(engNack), .engRxByte(engRxByte)
  );

  always #5 clk = ~clk;

  // Bus engine responder: logs each request, answers one cycle later.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (engReq && rstN) begin
        if (logN < 64) begin
          logOp[logN] = engOp;
          logByte[logN] = engByte;
        end
        logN++;
        @(posedge clk); #1;
        engDone = 1;
        engNack = nackAll;
        engRxByte = 8'hA0 + 8'(rdCnt);
        if (engOp == 3'd4) rdCnt++;
        @(posedge clk); #1;
        engDone = 0;
        engNack = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic putSlot(input int idx, input logic [4:0] op);
    cmdWr = 1; cmdWrAddr = 5'(idx); cmdWrData = op;
    step(1);
    cmdWr = 0;
  endtask

  task automatic pushTx(input logic [7:0] b);
    txPush = 1; txData = b;
    step(1);
    txPush = 0;
  endtask

  task automatic clearIrq(input logic [12:0] m);
    irqClr = 1; irqClrMask = m;
    step(1);
    irqClr = 0;
  endtask

  task automatic go();
    launch = 1;
    step(1);
    launch = 0;
  endtask

  task automatic waitIdle(input string tag);
    for (int i = 0; i < 3000 && busy; i++) step(1);
    chk(tag, busy, 0);
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 engReq", engReq, 0);
    chk("R1 rawIrq", rawIrq, 0);
    chk("R1 rxNotEmpty", rxNotEmpty, 0);
    chk("R1 txNotFull", txNotFull, 1);
    chk("R1 irq", irq, 0);
  endtask

  task automatic testWriteLoop();
    putSlot(0, 5'h01); putSlot(1, 5'h05); putSlot(2, 5'h13);
    putSlot(3, 5'h1D); putSlot(4, 5'h09); putSlot(5, 5'h13);
    putSlot(6, 5'h18); putSlot(7, 5'h1F); putSlot(8, 5'h00);
    jumpDest = 3; loopInit = 2; addrWord = 16'h0A5A;
    pushTx(8'h11); pushTx(8'h22); pushTx(8'h33);
    clearIrq(13'h1FFF);
    logN = 0; nackAll = 0;
    go();
    chk("R2 busy after launch", busy, 1);
    waitIdle("R6 write program ends");
    chk("R5 primitive count (3 bytes from loop 2)", logN, 10);
    chk("R3 op0 start", logOp[0], 0);
    chk("R4 op1 write", logOp[1], 3);
    chk("R4 addr low byte", logByte[1], 8'h5A);
    chk("R3 op2 sample", logOp[2], 7);
    chk("R4 byte 1", logByte[3], 8'h11);
    chk("R4 byte 2", logByte[5], 8'h22);
    chk("R5 byte 3", logByte[7], 8'h33);
    chk("R3 op9 stop", logOp[9], 2);
    chk("R6 done bit", rawIrq[12], 1);
    chk("R7 no abort on ACK", rawIrq[0], 0);
  endtask

  task automatic testReadStall();
    putSlot(0, 5'h01); putSlot(1, 5'h04); putSlot(2, 5'h15);
    putSlot(3, 5'h12); putSlot(4, 5'h16); putSlot(5, 5'h18);
    putSlot(6, 5'h12); putSlot(7, 5'h17); putSlot(8, 5'h1F);
    putSlot(9, 5'h00);
    jumpDest = 3; loopInit = 3; addrWord = 16'hF3C0; rxWater = 2;
    clearIrq(13'h1FFF);
    logN = 0; rdCnt = 0; nackAll = 1;
    go();
    step(300);
    chk("R9 stalled on full RX busy", busy, 1);
    chk("R9 stalled no request", engReq, 0);
    chk("R9 primitives before stall", logN, 11);
    chk("R4 addr high byte", logByte[1], 8'hF3);
    chk("R14 rxNotEmpty", rxNotEmpty, 1);
    chk("R11 rx above watermark", rawIrq[2], 1);
    chk("R7 ignored NACK keeps running", rawIrq[0], 0);
    for (int i = 0; i < 4; i++) begin
      chk("R10 rx order", rxData, 8'hA0 + 8'(i));
      rxPop = 1; step(1); rxPop = 0;
    end
    waitIdle("R9 resumes after pop");
    chk("R10 fifth byte", rxData, 8'hA4);
    rxPop = 1; step(1); rxPop = 0;
    chk("R14 rx drained", rxNotEmpty, 0);
    chk("R5 total primitives", logN, 14);
    chk("R10 last read op", logOp[11], 4);
    chk("R4 final nack", logOp[12], 6);
    chk("R4 final stop", logOp[13], 2);
    chk("R6 read done", rawIrq[12], 1);
    nackAll = 0;
    clearIrq(13'h1FFF);
    step(2);
    chk("R11 rx below watermark stays clear", rawIrq[2], 0);
  endtask

  task automatic testNackAbort();
    putSlot(0, 5'h01); putSlot(1, 5'h05); putSlot(2, 5'h13);
    putSlot(3, 5'h1F); putSlot(4, 5'h00);
    clearIrq(13'h1FFF);
    logN = 0; nackAll = 1;
    go();
    waitIdle("R7 abort idle");
    chk("R7 no stop after nack", logN, 3);
    chk("R7 abort bit", rawIrq[0], 1);
    chk("R7 no done bit", rawIrq[12], 0);
    nackAll = 0;
  endtask

  task automatic testBadOp();
    putSlot(0, 5'h02);
    clearIrq(13'h1FFF);
    logN = 0;
    go();
    step(3);
    chk("R8 idle", busy, 0);
    chk("R8 bad-op bit", rawIrq[11], 1);
    chk("R8 no done", rawIrq[12], 0);
    chk("R8 no request", logN, 0);
  endtask

  task automatic testTxStall();
    putSlot(0, 5'h1D); putSlot(1, 5'h00);
    clearIrq(13'h1FFF);
    logN = 0;
    go();
    step(20);
    chk("R9 empty TX stall busy", busy, 1);
    chk("R9 empty TX no done", rawIrq[12], 0);
    pushTx(8'h77);
    step(5);
    chk("R9 TX stall released", busy, 0);
    chk("R9 done after release", rawIrq[12], 1);
  endtask

  task automatic testIrqRegs();
    irqEn = 13'h1000;
    step(1);
    chk("R12 masked", maskedIrq, 13'h1000);
    chk("R12 irq out", irq, 1);
    irqEn = 13'h0001;
    step(1);
    chk("R12 masked off", maskedIrq, 0);
    chk("R12 irq low", irq, 0);
    putSlot(0, 5'h03);
    go();
    step(3);
    clearIrq(13'h1000);
    chk("R12 selected bit cleared", rawIrq[12], 0);
    chk("R12 other bit kept", rawIrq[11], 1);
    clearIrq(13'h0800);
    chk("R12 second clear", rawIrq[11], 0);
  endtask

  task automatic testTxWater();
    txWater = 2;
    step(2);
    chk("R11 tx below watermark", rawIrq[4], 1);
    pushTx(8'h01); pushTx(8'h02);
    clearIrq(13'h1FFF);
    step(2);
    chk("R11 tx at watermark clear", rawIrq[4], 0);
    pushTx(8'h03);
    chk("R14 not yet full", txNotFull, 1);
    pushTx(8'h04);
    chk("R14 tx full", txNotFull, 0);
    txWater = 0;
  endtask

  task automatic testEnable();
    putSlot(0, 5'h01); putSlot(1, 5'h1D); putSlot(2, 5'h09);
    putSlot(3, 5'h18); putSlot(4, 5'h1F); putSlot(5, 5'h00);
    jumpDest = 1; loopInit = 3;
    enable = 0;
    logN = 0;
    go();
    step(3);
    chk("R2 launch ignored when disabled", busy, 0);
    chk("R2 no request when disabled", logN, 0);
    enable = 1;
    step(1);
    go();
    step(4);
    chk("R13 running before disable", busy, 1);
    enable = 0;
    step(1);
    chk("R13 idle after disable", busy, 0);
    chk("R13 request dropped", engReq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    testReset();
    enable = 1;
    testWriteLoop();
    testReadStall();
    testNackAbort();
    testBadOp();
    testTxStall();
    testIrqRegs();
    testTxWater();
    testEnable();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule